// File: doc/BRIEF.md
# Runt-Free Clock Output Enable Bank

This block sits between a distributed source clock and a bank of clock output pins. Each output has one enable bit in a 16-bit configuration vector, made up of two 8-bit configuration registers. While its bit is 1 the output passes full source clock pulses. While its bit is 0 the output is held low and then released to high impedance. Each output has a drive-enable signal that models the pad's tri-state control.

An enable bit can change at any moment, with no fixed relation to the source clock. The block passes each bit through a synchronizer and updates the gate only while the source clock is low. As a result, an output starts or stops only between whole pulses and never emits a shortened pulse. A dedicated feedback output is always driven and always toggling, so a loop that aligns edges against it keeps its reference whatever the enable bits say. All enables come out of reset in the enabled state.

Top module: `clkout_enable_bank`

## Requirements
- R1: While `rst` is sampled high, every `drv_en` bit is 1 and every `clk_out` bit passes the source clock, whatever the value on `en_cfg`.
- R2: When `en_cfg[i]` is 1 for a long enough time, `clk_out[i]` is high during every high phase of `clk_src`. When `en_cfg[i]` is 0 for a long enough time, `clk_out[i]` stays low.
- R3: Let P1, P2 and P3 be the first, second and third rising edges of `clk_src` after `en_cfg` changes. The new value first shows on `clk_out` in the high phase that starts at P3. The high phases that start at P1 and P2 still reflect the old value.
- R4: No runt pulses. `clk_out` is low whenever `clk_src` is low. Within a high phase of `clk_src`, `clk_out` holds one level: high for the whole phase or low for the whole phase.
- R5: When an enable bit goes from 1 to 0, `drv_en[i]` falls at P3. By that time `clk_out[i]` has already been low for a full low phase. While `drv_en[i]` is 0 the output is in high impedance.
- R6: When an enable bit goes from 0 to 1, `drv_en[i]` rises at P2. This is one full cycle before the first pulse passes at P3.
- R7: `drv_en[i]` is 1 at every moment that `clk_out[i]` is high.
- R8: `fb_clk` always equals `clk_src` and `fb_drv_en` is always 1. Neither depends on any value of `en_cfg`.
- R9: Each bit of `en_cfg` affects only its own `clk_out` and `drv_en` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be gated and distributed |
| rst | input | 1 | Synchronous active-high reset; all outputs enabled |
| en_cfg | input | OUTS (16) | Per-output enable bits, 1 = output on |
| clk_out | output | OUTS (16) | Gated clock outputs |
| drv_en | output | OUTS (16) | Per-output drive enable, 0 = high impedance |
| fb_clk | output | 1 | Feedback clock, never gated |
| fb_drv_en | output | 1 | Feedback drive enable, always 1 |

## Verification
The hardest case to reach is an enable bit that changes again before its previous change has finished crossing the synchronizer. In that case the drive enable and the gate hold different values for a cycle. The stimulus toggles the whole vector every cycle, applies single-cycle pulses of one and of zero, and alternates the bit patterns. A scoreboard checks each sampled phase against the value that was applied three edges earlier. It also checks every cycle that each output's high phase is all high or all low, so a partial pulse would be reported.

// File: rtl/clkout_enable_bank_pkg.sv
package clkout_enable_bank_pkg;
  localparam int unsigned OEB_OUTS_DEFAULT   = 16;
  localparam int unsigned OEB_STAGES_DEFAULT = 2;

  typedef enum logic {
    OEB_OFF = 1'b0,
    OEB_ON  = 1'b1
  } oeb_state_e;
endpackage

// File: rtl/oeb_sync_bit.sv
module oeb_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] taps
);
  import clkout_enable_bank_pkg::*;

  // Shift chain; reset loads the enabled state into every stage
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= {STAGES{OEB_ON}};
    end else begin
      taps <= {taps[STAGES-2:0], din};
    end
  end
endmodule

// File: rtl/oeb_gate_cell.sv
module oeb_gate_cell #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] taps,
  output logic              gclk,
  output logic              oe
);
  import clkout_enable_bank_pkg::*;

  oeb_state_e hold_q;

  // The gate state changes only on the falling edge, while clk is low
  always_ff @(negedge clk) begin
    if (rst) begin
      hold_q <= OEB_ON;
    end else begin
      hold_q <= oeb_state_e'(taps[STAGES-1]);
    end
  end

  assign gclk = clk & hold_q;

  // Stays high while any stage or the gate still says on. This gives an
  // early rise on enable and a late fall on disable.
  always_ff @(posedge clk) begin
    if (rst) begin
      oe <= 1'b1;
    end else begin
      oe <= (|taps) | hold_q;
    end
  end
endmodule

// File: rtl/clkout_enable_bank.sv
module clkout_enable_bank #(
  parameter int unsigned OUTS   = clkout_enable_bank_pkg::OEB_OUTS_DEFAULT,
  parameter int unsigned STAGES = clkout_enable_bank_pkg::OEB_STAGES_DEFAULT
) (
  input  logic            clk_src,
  input  logic            rst,
  input  logic [OUTS-1:0] en_cfg,
  output logic [OUTS-1:0] clk_out,
  output logic [OUTS-1:0] drv_en,
  output logic            fb_clk,
  output logic            fb_drv_en
);
  localparam int unsigned LAST_OUT = OUTS - 1;

  for (genvar g = 0; g <= LAST_OUT; g++) begin : g_out
    logic [STAGES-1:0] taps;

    oeb_sync_bit #(.STAGES(STAGES)) u_sync (
      .clk  (clk_src),
      .rst  (rst),
      .din  (en_cfg[g]),
      .taps (taps)
    );

    oeb_gate_cell #(.STAGES(STAGES)) u_gate (
      .clk  (clk_src),
      .rst  (rst),
      .taps (taps),
      .gclk (clk_out[g]),
      .oe   (drv_en[g])
    );
  end

  // The feedback path has no gate, so the loop reference is always present
  assign fb_clk    = clk_src;
  assign fb_drv_en = 1'b1;
endmodule

// File: rtl/clkout_enable_bank_chk.sv
module clkout_enable_bank_chk #(
  parameter int unsigned OUTS = 16
) (
  input logic            clk_src,
  input logic            rst,
  input logic [OUTS-1:0] en_cfg,
  input logic [OUTS-1:0] clk_out,
  input logic [OUTS-1:0] drv_en,
  input logic            fb_clk,
  input logic            fb_drv_en
);
  logic [2:0] settle_q;

  always_ff @(posedge clk_src) begin
    if (rst) begin
      settle_q <= '0;
    end else if (settle_q != 3'd4) begin
      settle_q <= settle_q + 3'd1;
    end
  end

  // R4: gated outputs are low whenever the source is low
  always_comb begin
    if (!clk_src) begin
      assert_low_when_src_low_R4 : assert (clk_out == '0);
    end
  end

  // R7: an output never pulses without its drive enable
  always_comb begin
    if (!rst) begin
      assert_pulse_needs_drive_R7 : assert ((clk_out & ~drv_en) == '0);
    end
  end

  // R8: the feedback pair ignores the enables
  always_comb begin
    assert_fb_follows_src_R8 : assert (fb_clk == clk_src && fb_drv_en == 1'b1);
  end

  // R5: zero held across the window drops the drive enable
  property p_drive_drops_R5;
    @(posedge clk_src) disable iff (rst)
      (settle_q == 3'd4) |->
        ((~$past(en_cfg, 2) & ~$past(en_cfg, 3) & drv_en) == '0);
  endproperty
  assert_drive_drops_R5 : assert property (p_drive_drops_R5);

  // R6: a one applied earlier has already raised the drive enable
  property p_drive_rises_R6;
    @(posedge clk_src) disable iff (rst)
      (settle_q == 3'd4) |-> (($past(en_cfg, 2) & ~drv_en) == '0);
  endproperty
  assert_drive_rises_R6 : assert property (p_drive_rises_R6);
endmodule

bind clkout_enable_bank clkout_enable_bank_chk #(.OUTS(OUTS)) u_chk (.*);

// File: tb/test_clkout_enable_bank.sv
module test_clkout_enable_bank;
  localparam int OUTS = 16;
  localparam logic [OUTS-1:0] ONES = '1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [OUTS-1:0] en_cfg = '0;
  logic [OUTS-1:0] clk_out;
  logic [OUTS-1:0] drv_en;
  logic            fb_clk;
  logic            fb_drv_en;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done    = 0;
  bit mon_end = 0;
  logic [OUTS-1:0] expq[$];

  clkout_enable_bank #(.OUTS(OUTS)) i_clkout_enable_bank (
    .clk_src   (clk),
    .rst       (rst),
    .en_cfg    (en_cfg),
    .clk_out   (clk_out),
    .drv_en    (drv_en),
    .fb_clk    (fb_clk),
    .fb_drv_en (fb_drv_en)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [OUTS-1:0] act,
                       input logic [OUTS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one value per cycle and records it as the expected item
  task automatic drive(input logic [OUTS-1:0] v);
    @(posedge clk);
    #2;
    rst = 1'b0;
    en_cfg = v;
    expq.push_back(v);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #3;
    check("R1 drive enables in reset", drv_en, ONES);
    check("R1 outputs pass in reset", clk_out, ONES);
    #3;
    check("R4 low phase in reset", clk_out, '0);
    expq.push_back(ONES);
    expq.push_back(ONES);
    expq.push_back(ONES);
    started = 1;
    repeat (3) drive(ONES);
    repeat (5) drive('0);
    repeat (4) drive(ONES);
    for (int b = 0; b < OUTS; b++) begin
      repeat (4) drive(OUTS'(1) << b);   // R9 walking single bit
    end
    repeat (4) drive(16'h5555);
    repeat (4) drive(16'hAAAA);
    drive(ONES);                          // single-cycle pulse of one
    repeat (4) drive('0);
    repeat (4) drive(ONES);
    drive('0);                            // single-cycle pulse of zero
    repeat (4) drive(ONES);
    for (int k = 0; k < 12; k++) begin
      drive(k[0] ? 16'hF0F0 : 16'h0F0F);  // toggling every cycle
    end
    repeat (4) drive(16'h8001);
    done = 1;
  end

  // Monitor: compares each cycle against the value applied three edges earlier
  initial begin
    logic [OUTS-1:0] early;
    wait (started);
    forever begin
      @(posedge clk);
      #1;
      early = clk_out;
      #2;
      if (expq.size() < 4) break;
      check("R2 R3 R9 gated output", clk_out, expq[0]);
      check("R4 full-width pulse", early, clk_out);
      check("R5 R6 drive enable", drv_en, expq[0] | expq[1]);
      check("R7 drive during pulse", clk_out & ~drv_en, '0);
      check("R8 feedback high", {fb_clk, fb_drv_en}, 2'b11);
      void'(expq.pop_front());
      #3;
      check("R4 low phase", clk_out, '0);
      check("R8 feedback low", {fb_clk, fb_drv_en}, 2'b01);
    end
    mon_end = 1;
  end

  initial begin
    fork
      wait (mon_end);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule